// File: doc/BRIEF.md
# Nested Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. Each cycle it takes two vectors: the pending requests, already masked, and the lines currently in service. It ranks both vectors on a circular priority ring. The top of the ring is set by a rotation offset. The block raises an interrupt request only when the best pending line outranks the best line in service, so a lower-ranked source can never preempt a handler that is still running. A nesting mode is available for a primary controller that has a secondary one chained onto its cascade line. In that mode the in-service bit of the cascade line is left out of the comparison, so the secondary can raise further requests while its own earlier request is still being serviced.

When the processor acknowledges, the block registers a one-cycle response. The response carries the winning line number and the interrupt vector, which is the programmed base plus that line number. It also carries a one-hot set mask for the in-service register, which the owner of that register applies. With automatic end-of-interrupt enabled, the response also carries a matching clear mask; the owner applies the set and then the clear, so the bit ends up clear. If rotate-on-automatic-EOI is also enabled, the response gives the new rotation offset. An acknowledge that arrives with nothing qualified returns the lowest-ranked line number as a spurious response and requests no changes. Acknowledge and every mode input are plain level or strobe controls. The response is a one-cycle valid pulse with no back-pressure, because the processor accepts it in the cycle it appears. The line count must be a power of two.

Top module: `nest_prio_resolver`

## Requirements
- R1: The rank of a line is its distance from the rotation offset going upward, wrapping modulo N_LINES (rank 0 is the line equal to the offset). The acknowledged winner is the pending line with the smallest rank.
- R2: With an all-zero pending vector, irq_o is low.
- R3: irq_o goes high only when the best pending rank is strictly smaller than the best rank over the compared in-service vector. An in-service line of equal or better rank holds the request off.
- R4: When nest_mode_i is high, in-service bit CASCADE_LINE (2 by default) is left out of the comparison in R3. Pending bit CASCADE_LINE is still ranked normally.
- R5: irq_o is registered. It shows the decision for the inputs present at the previous rising edge, and it is low while rst_n is low.
- R6: ack_i high at an edge with a qualified request gives, one cycle later, resp_valid_o high, resp_spur_o low, resp_line_o equal to the winner, and isr_set_o equal to the one-hot mask of the winner. With ack_i low, resp_valid_o is low in the next cycle.
- R7: ack_i with no qualified request gives resp_valid_o high, resp_spur_o high and resp_line_o equal to N_LINES-1. isr_set_o, isr_clr_o and rot_load_o are all zero.
- R8: resp_vec_o equals base_i plus resp_line_o, modulo 2^VEC_W. This also holds for spurious responses.
- R9: On a non-spurious acknowledge with aeoi_i high, isr_clr_o equals isr_set_o. With aeoi_i low, isr_clr_o is zero.
- R10: rot_load_o pulses only on a non-spurious acknowledge with both aeoi_i and rot_aeoi_i high. It then carries rot_next_o = (winner + 1) mod N_LINES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | N_LINES | Masked pending requests |
| isr_i | input | N_LINES | Lines currently in service |
| rot_off_i | input | log2(N_LINES) | Rotation offset (line with rank 0) |
| nest_mode_i | input | 1 | Ignore the cascade line's in-service bit |
| aeoi_i | input | 1 | Automatic end-of-interrupt enable |
| rot_aeoi_i | input | 1 | Rotate on automatic end-of-interrupt |
| base_i | input | VEC_W | Vector base |
| ack_i | input | 1 | Processor acknowledge strobe |
| irq_o | output | 1 | Registered interrupt request |
| resp_valid_o | output | 1 | Acknowledge response valid pulse |
| resp_spur_o | output | 1 | Response is spurious |
| resp_line_o | output | log2(N_LINES) | Returned line number |
| resp_vec_o | output | VEC_W | Returned vector |
| isr_set_o | output | N_LINES | In-service bits to set |
| isr_clr_o | output | N_LINES | In-service bits to clear (after set) |
| rot_load_o | output | 1 | Load new rotation offset |
| rot_next_o | output | log2(N_LINES) | New rotation offset |

## Verification
The bench builds the block with N_LINES = 8, CASCADE_LINE = 2 and VEC_W = 8. With eight lines, a random 3-bit offset sweeps every rotation of the ring, including the wrap from line 7 back to line 0 in both the winner and the next offset. With the cascade line at 2, nesting mode can be set up against a real in-service conflict on that line. The 8-bit base lets a high base such as 0xF8 plus the spurious line reach the top vector value without wrap. Random vectors and modes are mixed with directed cases: equal-rank blocking, nesting, and all four combinations of the end-of-interrupt bits.

// File: rtl/nest_prio_pkg.sv
package nest_prio_pkg;
  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_REAL = 2'd1,
    ACK_SPUR = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/nest_prio_scan.sv
module nest_prio_scan #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N),
  parameter int unsigned PW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] off_i,
  output logic [PW-1:0] pri_o,
  output logic [IW-1:0] line_o,
  output logic          hit_o
);
  logic [N-1:0] rot;

  // rotate so that the offset line lands at position 0
  always_comb begin
    for (int k = 0; k < N; k++) begin
      rot[k] = vec_i[IW'(IW'(k) + off_i)];
    end
  end

  // priority encode: lowest set position, N when empty
  always_comb begin
    pri_o = PW'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) pri_o = PW'(k);
    end
  end

  // un-rotate back to a line number
  assign line_o = IW'(pri_o[IW-1:0] + off_i);
  assign hit_o  = (pri_o != PW'(N));

  always_comb begin
    if (vec_i == '0) assert_empty_sentinel_R2: assert (pri_o == PW'(N));
    if (hit_o)       assert_winner_pending_R1: assert (vec_i[line_o]);
  end
endmodule

// File: rtl/nest_ack_ctrl.sv
module nest_ack_ctrl
  import nest_prio_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N),
  parameter int unsigned VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_i,
  input  logic          want_i,
  input  logic [IW-1:0] line_i,
  input  logic          aeoi_i,
  input  logic          rot_aeoi_i,
  input  logic [VW-1:0] base_i,
  output logic          resp_valid_o,
  output logic          resp_spur_o,
  output logic [IW-1:0] resp_line_o,
  output logic [VW-1:0] resp_vec_o,
  output logic [N-1:0]  isr_set_o,
  output logic [N-1:0]  isr_clr_o,
  output logic          rot_load_o,
  output logic [IW-1:0] rot_next_o
);
  localparam logic [IW-1:0] SPUR_LINE = IW'(N - 1);

  ack_kind_e     kind;
  logic [IW-1:0] sel_line;
  logic [N-1:0]  sel_onehot;
  logic          real_ack;

  always_comb begin
    if (!ack_i)      kind = ACK_NONE;
    else if (want_i) kind = ACK_REAL;
    else             kind = ACK_SPUR;
  end

  assign real_ack   = (kind == ACK_REAL);
  assign sel_line   = real_ack ? line_i : SPUR_LINE;
  assign sel_onehot = N'(1) << sel_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid_o <= 1'b0;
      resp_spur_o  <= 1'b0;
      resp_line_o  <= '0;
      resp_vec_o   <= '0;
      isr_set_o    <= '0;
      isr_clr_o    <= '0;
      rot_load_o   <= 1'b0;
      rot_next_o   <= '0;
    end else begin
      resp_valid_o <= (kind != ACK_NONE);
      resp_spur_o  <= (kind == ACK_SPUR);
      resp_line_o  <= sel_line;
      resp_vec_o   <= base_i + VW'(sel_line);
      isr_set_o    <= real_ack ? sel_onehot : '0;
      isr_clr_o    <= (real_ack && aeoi_i) ? sel_onehot : '0;
      rot_load_o   <= real_ack && aeoi_i && rot_aeoi_i;
      rot_next_o   <= IW'(sel_line + 1'b1);
    end
  end

  assert_set_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_set_o) && (isr_set_o != '0 || !resp_valid_o || resp_spur_o));

  assert_spur_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_spur_o) |->
      (resp_line_o == SPUR_LINE && isr_set_o == '0 && isr_clr_o == '0 && !rot_load_o));

  assert_aeoi_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && !resp_spur_o && $past(aeoi_i)) |-> (isr_clr_o == isr_set_o));

  assert_rot_needs_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rot_load_o |-> (resp_valid_o && !resp_spur_o && isr_clr_o != '0));
endmodule

// File: rtl/nest_prio_resolver.sv
module nest_prio_resolver #(
  parameter int unsigned N_LINES      = 8,
  parameter int unsigned CASCADE_LINE = 2,
  parameter int unsigned VEC_W        = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_LINES-1:0]         pend_i,
  input  logic [N_LINES-1:0]         isr_i,
  input  logic [$clog2(N_LINES)-1:0] rot_off_i,
  input  logic                       nest_mode_i,
  input  logic                       aeoi_i,
  input  logic                       rot_aeoi_i,
  input  logic [VEC_W-1:0]           base_i,
  input  logic                       ack_i,
  output logic                       irq_o,
  output logic                       resp_valid_o,
  output logic                       resp_spur_o,
  output logic [$clog2(N_LINES)-1:0] resp_line_o,
  output logic [VEC_W-1:0]           resp_vec_o,
  output logic [N_LINES-1:0]         isr_set_o,
  output logic [N_LINES-1:0]         isr_clr_o,
  output logic                       rot_load_o,
  output logic [$clog2(N_LINES)-1:0] rot_next_o
);
  localparam int unsigned IW = $clog2(N_LINES);
  localparam int unsigned PW = $clog2(N_LINES + 1);

  logic [N_LINES-1:0] isr_cmp;
  logic [PW-1:0]      pend_pri, serv_pri;
  logic [IW-1:0]      pend_line, serv_line;
  logic               pend_hit, serv_hit;
  logic               want;

  always_comb begin
    isr_cmp = isr_i;
    if (nest_mode_i) isr_cmp[CASCADE_LINE] = 1'b0;
  end

  nest_prio_scan #(.N(N_LINES), .IW(IW), .PW(PW)) u_pend_scan (
    .vec_i (pend_i),
    .off_i (rot_off_i),
    .pri_o (pend_pri),
    .line_o(pend_line),
    .hit_o (pend_hit)
  );

  nest_prio_scan #(.N(N_LINES), .IW(IW), .PW(PW)) u_serv_scan (
    .vec_i (isr_cmp),
    .off_i (rot_off_i),
    .pri_o (serv_pri),
    .line_o(serv_line),
    .hit_o (serv_hit)
  );

  assign want = pend_hit && (pend_pri < serv_pri);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= want;
  end

  nest_ack_ctrl #(.N(N_LINES), .IW(IW), .VW(VEC_W)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .want_i      (want),
    .line_i      (pend_line),
    .aeoi_i      (aeoi_i),
    .rot_aeoi_i  (rot_aeoi_i),
    .base_i      (base_i),
    .resp_valid_o(resp_valid_o),
    .resp_spur_o (resp_spur_o),
    .resp_line_o (resp_line_o),
    .resp_vec_o  (resp_vec_o),
    .isr_set_o   (isr_set_o),
    .isr_clr_o   (isr_clr_o),
    .rot_load_o  (rot_load_o),
    .rot_next_o  (rot_next_o)
  );

  assert_irq_needs_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(pend_i) != '0));

  assert_serv_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (serv_hit && serv_pri == '0) |=> !irq_o);

  assert_line_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    serv_hit |-> isr_cmp[serv_line]);
endmodule

// File: tb/test_nest_prio_resolver.sv
module test_nest_prio_resolver;
  localparam int N = 8;
  localparam int CASC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pend_i = '0, isr_i = '0, base_i = '0;
  logic [2:0] rot_off_i = '0;
  logic       nest_mode_i = 1'b0, aeoi_i = 1'b0, rot_aeoi_i = 1'b0, ack_i = 1'b0;
  logic       irq_o, resp_valid_o, resp_spur_o, rot_load_o;
  logic [2:0] resp_line_o, rot_next_o;
  logic [7:0] resp_vec_o, isr_set_o, isr_clr_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit prev_want = 1'b0;

  always #2.5 clk = ~clk;

  nest_prio_resolver #(.N_LINES(N), .CASCADE_LINE(CASC), .VEC_W(8)) i_nest_prio_resolver (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .isr_i(isr_i), .rot_off_i(rot_off_i),
    .nest_mode_i(nest_mode_i), .aeoi_i(aeoi_i), .rot_aeoi_i(rot_aeoi_i), .base_i(base_i),
    .ack_i(ack_i), .irq_o(irq_o), .resp_valid_o(resp_valid_o), .resp_spur_o(resp_spur_o),
    .resp_line_o(resp_line_o), .resp_vec_o(resp_vec_o), .isr_set_o(isr_set_o),
    .isr_clr_o(isr_clr_o), .rot_load_o(rot_load_o), .rot_next_o(rot_next_o)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int rank_of(logic [7:0] v, int off);
    for (int p = 0; p < N; p++) if (v[(p + off) % N]) return p;
    return N;
  endfunction

  task automatic step(string tag, logic [7:0] pd, logic [7:0] sv, int off, bit nest,
                      bit ae, bit ra, bit ack, logic [7:0] base);
    logic [7:0] svm;
    int pr, sr, ln;
    bit want;
    @(negedge clk);
    pend_i = pd; isr_i = sv; rot_off_i = 3'(off); nest_mode_i = nest;
    aeoi_i = ae; rot_aeoi_i = ra; ack_i = ack; base_i = base;
    svm = sv;
    if (nest) svm[CASC] = 1'b0;
    pr = rank_of(pd, off);
    sr = rank_of(svm, off);
    want = (pr < N) && (pr < sr);
    ln = want ? (pr + off) % N : N - 1;
    #1;
    chk("R5 irq before edge", int'(irq_o), int'(prev_want));
    @(posedge clk); #1;
    chk(tag, int'(irq_o), int'(want));
    chk("R6 resp_valid", int'(resp_valid_o), int'(ack));
    if (ack) begin
      chk(want ? "R6 spur flag" : "R7 spur flag", int'(resp_spur_o), int'(!want));
      chk(want ? "R1 winner line" : "R7 spurious line", int'(resp_line_o), ln);
      chk("R8 vector", int'(resp_vec_o), int'(8'(base + 8'(ln))));
      chk(want ? "R6 set mask" : "R7 set mask", int'(isr_set_o), want ? (1 << ln) : 0);
      chk("R9 clr mask", int'(isr_clr_o), (want && ae) ? (1 << ln) : 0);
      chk("R10 rot load", int'(rot_load_o), int'(want && ae && ra));
      if (want && ae && ra) chk("R10 rot next", int'(rot_next_o), (ln + 1) % N);
    end
    prev_want = want;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R5 irq in reset", int'(irq_o), 0);
    chk("R6 resp in reset", int'(resp_valid_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 rotation
    step("R1 irq", 8'b1000_0001, 8'h00, 0, 0, 0, 0, 1, 8'h20);
    step("R1 irq", 8'b1000_0001, 8'h00, 5, 0, 0, 0, 1, 8'h20);
    step("R1 irq", 8'b0001_0010, 8'h00, 4, 0, 0, 0, 1, 8'h40);
    // R2 empty, spurious ack (R7), high base (R8)
    step("R2 irq", 8'h00, 8'h00, 3, 0, 0, 0, 1, 8'hF8);
    // R3 equal rank blocks, better rank raises
    step("R3 irq", 8'b0000_1000, 8'b0000_1000, 0, 0, 0, 0, 1, 8'h08);
    step("R3 irq", 8'b0000_0100, 8'b0000_1000, 0, 0, 0, 0, 0, 8'h08);
    step("R3 irq", 8'b0000_0001, 8'b0000_1000, 1, 0, 0, 0, 1, 8'h08);
    // R4 nesting on cascade line
    step("R4 irq", 8'b0000_0100, 8'b0000_0100, 0, 0, 0, 0, 1, 8'h00);
    step("R4 irq", 8'b0000_0100, 8'b0000_0100, 0, 1, 0, 0, 1, 8'h00);
    step("R4 irq", 8'b0010_0000, 8'b0000_0100, 0, 1, 0, 0, 0, 8'h00);
    step("R4 irq", 8'b0010_0000, 8'b0000_0100, 0, 0, 0, 0, 0, 8'h00);
    // R9 / R10 end-of-interrupt combinations
    step("R9 irq", 8'b0100_0000, 8'h00, 0, 0, 1, 0, 1, 8'h10);
    step("R10 irq", 8'b0100_0000, 8'h00, 0, 0, 1, 1, 1, 8'h10);
    step("R10 irq", 8'b1000_0000, 8'h00, 2, 0, 1, 1, 1, 8'h10);
    step("R10 irq", 8'b1000_0000, 8'h00, 2, 0, 0, 1, 1, 8'h10);
    step("R10 irq", 8'h00, 8'h00, 2, 0, 1, 1, 1, 8'h10);

    for (int i = 0; i < 400; i++) begin
      step("R3 irq random", 8'($urandom), 8'($urandom & $urandom), int'($urandom % 8),
           bit'($urandom), bit'($urandom), bit'($urandom), bit'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule